// File: doc/BRIEF.md
# Dual-Channel Serial Control Register

This block is the digital control front end of a two-path phase and amplitude
controller. A host shifts 14-bit control words in over a three-wire serial
port (serial clock, data, latch strobe). A strobe pulse copies the assembled
word into one of two channel registers. The top bit of the word picks the
channel. Channel 1 holds only a 5-bit phase code. Channel 2 holds a 5-bit phase
code, a 4-bit attenuation code and a 4-bit loss-stabilizer code. These codes
drive the analog switching elements, which are outside this block.

All three serial pins are brought into the block's core clock domain through
synchronizer stages, and their edges are found there. The serial clock must
therefore be slower than the core clock. A serial echo output repeats each
sampled data bit after the serial clock's falling edge, so the host can read
back what it sent. While the asynchronous active-low reset is held, both
channels load one of two boot states, chosen by a default-select pin. A
force-reference input blanks every output code to zero while it is high. The
programmed contents are kept and show again once it drops.

Top module: `dual_path_ctrl_regs`

## Requirements
- R1: While reset is asserted with boot_sel = 0, every output code is zero.
- R2: While reset is asserted with boot_sel = 1, ch1_phase = 5'b10000, ch2_phase = 5'b10000, ch2_atten = 4'b1111 and ch2_stab = 0.
- R3: The first serial bit sampled lands in word bit 0 and the fourteenth in bit 13. Fields: bit 13 channel select, bits 12..11 stabilizer code bits 3..2, bits 10..7 attenuation, bits 6..2 phase (bit 2 = phase LSB), bits 1..0 stabilizer code bits 1..0.
- R4: A strobe rising edge with word bit 13 = 0 loads ch1_phase from the phase field and leaves all channel 2 outputs unchanged.
- R5: A strobe rising edge with word bit 13 = 1 loads ch2_phase, ch2_atten and ch2_stab and leaves ch1_phase unchanged.
- R6: Shifting serial bits without a strobe edge leaves every output code unchanged.
- R7: After each serial clock falling edge, sdo equals the data bit sampled at the preceding rising edge.
- R8: While force_ref is high, every output code reads zero.
- R9: Words latched while force_ref is high are stored, and they appear on the outputs once force_ref is low.
- R10: A strobe after fewer or more than 14 serial clocks latches the last 14 bits shifted, in the order given in R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset; loads the boot state |
| sclk | input | 1 | Serial clock; data sampled on its rising edge |
| sdi | input | 1 | Serial data in |
| le | input | 1 | Latch strobe; rising edge transfers the word |
| boot_sel | input | 1 | Picks the boot state loaded during reset |
| force_ref | input | 1 | High forces all output codes to zero |
| sdo | output | 1 | Serial echo of sampled data |
| ch1_phase | output | 5 | Channel 1 phase code |
| ch2_phase | output | 5 | Channel 2 phase code |
| ch2_atten | output | 4 | Channel 2 attenuation code |
| ch2_stab | output | 4 | Channel 2 stabilizer code |

## Verification
The bench sweeps all 32 channel 1 phase codes, so every phase bit position is
checked on its own. Sixteen channel 2 words follow, with attenuation counting
up and the stabilizer counting down. This separates the split stabilizer field
from its neighbours. After each write the other channel is checked, which shows
whether the select bit is decoded the wrong way round. Strobes after 4 extra bits
and after 16 bits catch a register that shifts the wrong way or drops bits. A
write made while the reference state is forced shows that the stored value and
the blanked value are kept apart.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
    parameter int WORD_W = 14;
    parameter int PH_W   = 5;
    parameter int AT_W   = 4;
    parameter int ST_W   = 4;

    localparam int PH_LSB  = 2;
    localparam int AT_LSB  = PH_LSB + PH_W;
    localparam int SEL_BIT = WORD_W - 1;

    typedef struct packed {
        logic [PH_W-1:0] ch1_ph;
        logic [PH_W-1:0] ch2_ph;
        logic [AT_W-1:0] ch2_at;
        logic [ST_W-1:0] ch2_st;
    } chan_state_t;

    function automatic chan_state_t boot_state(input logic sel);
        chan_state_t s;
        s = '0;
        if (sel) begin
            s.ch1_ph = PH_W'(1) << (PH_W - 1);
            s.ch2_ph = PH_W'(1) << (PH_W - 1);
            s.ch2_at = '1;
        end
        return s;
    endfunction

    function automatic chan_state_t apply_word(input chan_state_t cur,
                                               input logic [WORD_W-1:0] w);
        chan_state_t s;
        s = cur;
        if (!w[SEL_BIT]) begin
            s.ch1_ph = w[AT_LSB-1:PH_LSB];
        end else begin
            s.ch2_ph = w[AT_LSB-1:PH_LSB];
            s.ch2_at = w[AT_LSB+AT_W-1:AT_LSB];
            s.ch2_st = {w[SEL_BIT-1 -: 2], w[1:0]};
        end
        return s;
    endfunction
endpackage

// File: rtl/dpc_pin_sync.sv
module dpc_pin_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    typedef struct packed {
        logic [STAGES-1:0][N-1:0] pipe;
        logic [N-1:0]             last;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.pipe[0] = pins_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
        st_d.last = st_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.pipe[STAGES-1];
    assign rise_o  = st_q.pipe[STAGES-1] & ~st_q.last;
    assign fall_o  = ~st_q.pipe[STAGES-1] & st_q.last;
endmodule

// File: rtl/dpc_shifter.sv
module dpc_shifter
    import dpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              echo_en,
    input  logic              bit_i,
    output logic [WORD_W-1:0] word_o,
    output logic              echo_o
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              echo;
    } shift_t;

    shift_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (shift_en) sh_d.word = {bit_i, sh_q.word[WORD_W-1:1]};
        if (echo_en)  sh_d.echo = sh_q.word[WORD_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign word_o = sh_q.word;
    assign echo_o = sh_q.echo;
endmodule

// File: rtl/dpc_chan_bank.sv
module dpc_chan_bank
    import dpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_sel,
    input  logic              load_en,
    input  logic [WORD_W-1:0] word_i,
    output chan_state_t       state_o
);
    chan_state_t cs_d, cs_q;

    always_comb begin
        cs_d = cs_q;
        if (load_en) cs_d = apply_word(cs_q, word_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= boot_state(boot_sel);
        else        cs_q <= cs_d;
    end

    assign state_o = cs_q;
endmodule

// File: rtl/dual_path_ctrl_regs.sv
module dual_path_ctrl_regs
    import dpc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk,
    input  logic            sdi,
    input  logic            le,
    input  logic            boot_sel,
    input  logic            force_ref,
    output logic            sdo,
    output logic [PH_W-1:0] ch1_phase,
    output logic [PH_W-1:0] ch2_phase,
    output logic [AT_W-1:0] ch2_atten,
    output logic [ST_W-1:0] ch2_stab
);
    localparam int PIN_SCLK = 0;
    localparam int PIN_SDI  = 1;
    localparam int PIN_LE   = 2;
    localparam int NPINS    = 3;

    logic [NPINS-1:0]  pin_lvl, pin_rise, pin_fall;
    logic              sclk_rise, sclk_fall, le_rise, sdi_s;
    logic [WORD_W-1:0] word;
    chan_state_t       held;

    dpc_pin_sync #(.N(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i ({le, sdi, sclk}),
        .level_o(pin_lvl),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    assign sclk_rise = pin_rise[PIN_SCLK];
    assign sclk_fall = pin_fall[PIN_SCLK];
    assign le_rise   = pin_rise[PIN_LE];
    assign sdi_s     = pin_lvl[PIN_SDI];

    dpc_shifter u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(sclk_rise),
        .echo_en (sclk_fall),
        .bit_i   (sdi_s),
        .word_o  (word),
        .echo_o  (sdo)
    );

    dpc_chan_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .boot_sel(boot_sel),
        .load_en (le_rise),
        .word_i  (word),
        .state_o (held)
    );

    always_comb begin
        ch1_phase = held.ch1_ph;
        ch2_phase = held.ch2_ph;
        ch2_atten = held.ch2_at;
        ch2_stab  = held.ch2_st;
        if (force_ref) begin
            ch1_phase = '0;
            ch2_phase = '0;
            ch2_atten = '0;
            ch2_stab  = '0;
        end
    end
endmodule

// File: rtl/dual_path_ctrl_chk.sv
module dual_path_ctrl_chk
    import dpc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              force_ref,
    input logic              sclk_rise,
    input logic              sclk_fall,
    input logic              le_rise,
    input logic              sdi_s,
    input logic [WORD_W-1:0] word,
    input logic              sdo,
    input chan_state_t       held,
    input logic [PH_W-1:0]   ch1_phase,
    input logic [PH_W-1:0]   ch2_phase,
    input logic [AT_W-1:0]   ch2_atten,
    input logic [ST_W-1:0]   ch2_stab
);
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !le_rise |=> $stable(held));

    assert_ch1_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (le_rise && !word[SEL_BIT]) |=>
            ($stable(held.ch2_ph) && $stable(held.ch2_at) && $stable(held.ch2_st)));

    assert_ch2_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (le_rise && word[SEL_BIT]) |=> $stable(held.ch1_ph));

    assert_shift_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |=> (word[SEL_BIT] == $past(sdi_s)));

    assert_echo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_fall |=> (sdo == $past(word[SEL_BIT])));

    assert_forced_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        force_ref |-> (ch1_phase == '0 && ch2_phase == '0 &&
                       ch2_atten == '0 && ch2_stab == '0));
endmodule

bind dual_path_ctrl_regs dual_path_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .force_ref(force_ref),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall),
    .le_rise  (le_rise),
    .sdi_s    (sdi_s),
    .word     (word),
    .sdo      (sdo),
    .held     (held),
    .ch1_phase(ch1_phase),
    .ch2_phase(ch2_phase),
    .ch2_atten(ch2_atten),
    .ch2_stab (ch2_stab)
);

// File: tb/dual_path_ctrl_regs_test.sv
module dual_path_ctrl_regs_test;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       sclk = 0, sdi = 0, le = 0, boot_sel = 0, force_ref = 0;
    logic       sdo;
    logic [4:0] ch1_phase, ch2_phase;
    logic [3:0] ch2_atten, ch2_stab;

    int checks = 0;
    int failures = 0;

    logic [4:0] e1p, e2p;
    logic [3:0] e2a, e2s;

    always #10 clk = ~clk;

    dual_path_ctrl_regs uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .le(le),
        .boot_sel(boot_sel), .force_ref(force_ref), .sdo(sdo),
        .ch1_phase(ch1_phase), .ch2_phase(ch2_phase),
        .ch2_atten(ch2_atten), .ch2_stab(ch2_stab)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_outs(input string req, input logic [4:0] p1, input logic [4:0] p2,
                              input logic [3:0] a2, input logic [3:0] s2);
        checks++;
        if (ch1_phase !== p1 || ch2_phase !== p2 || ch2_atten !== a2 || ch2_stab !== s2) begin
            failures++;
            $display("FAIL %s: got p1=%b p2=%b a2=%b s2=%b expected p1=%b p2=%b a2=%b s2=%b",
                     req, ch1_phase, ch2_phase, ch2_atten, ch2_stab, p1, p2, a2, s2);
        end
    endtask

    task automatic send_bit(input logic b, input bit chk_echo);
        sdi = b;
        wait_clk(6);
        sclk = 1;
        wait_clk(6);
        sclk = 0;
        wait_clk(6);
        if (chk_echo) begin
            checks++;
            if (sdo !== b) begin
                failures++;
                $display("FAIL R7: sdo got %b expected %b", sdo, b);
            end
        end
    endtask

    task automatic send_bits(input logic [15:0] v, input int n, input bit chk_echo);
        for (int i = 0; i < n; i++) send_bit(v[i], chk_echo);
    endtask

    task automatic strobe();
        le = 1;
        wait_clk(6);
        le = 0;
        wait_clk(6);
    endtask

    function automatic logic [13:0] mk(input logic sel, input logic [4:0] ph,
                                       input logic [3:0] at, input logic [3:0] sb);
        return {sel, sb[3], sb[2], at, ph, sb[1], sb[0]};
    endfunction

    function automatic void model_latch(input logic [13:0] w);
        if (!w[13]) e1p = w[6:2];
        else begin
            e2p = w[6:2];
            e2a = w[10:7];
            e2s = {w[12], w[11], w[1], w[0]};
        end
    endfunction

    task automatic write_word(input logic [13:0] w, input bit chk_echo);
        send_bits({2'b00, w}, 14, chk_echo);
        strobe();
        model_latch(w);
    endtask

    initial begin
        wait_clk(150000);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [13:0] w;
        // R1: boot state with select low
        boot_sel = 0;
        wait_clk(3);
        check_outs("R1", 5'd0, 5'd0, 4'd0, 4'd0);
        rst_n = 1;
        wait_clk(3);
        check_outs("R1", 5'd0, 5'd0, 4'd0, 4'd0);
        // R2: boot state with select high
        rst_n = 0;
        boot_sel = 1;
        wait_clk(3);
        check_outs("R2", 5'b10000, 5'b10000, 4'b1111, 4'd0);
        rst_n = 1;
        wait_clk(3);
        e1p = 5'b10000; e2p = 5'b10000; e2a = 4'b1111; e2s = 4'd0;
        check_outs("R2", e1p, e2p, e2a, e2s);

        // R3 R4: sweep all channel 1 phase codes; echo checked on the first word (R7)
        for (int p = 0; p < 32; p++) begin
            write_word(mk(1'b0, 5'(p), 4'(p % 16), 4'(15 - p % 16)), p == 0);
            check_outs("R4", e1p, e2p, e2a, e2s);
        end

        // R3 R5: channel 2 sweep; attenuation up, stabilizer down
        for (int i = 0; i < 16; i++) begin
            write_word(mk(1'b1, 5'((i * 7) % 32), 4'(i), 4'(15 - i)), 0);
            check_outs("R5", e1p, e2p, e2a, e2s);
        end

        // R6: shifting a full word without a strobe changes nothing
        send_bits({2'b00, mk(1'b1, 5'b01010, 4'b0101, 4'b1010)}, 14, 0);
        check_outs("R6", e1p, e2p, e2a, e2s);
        send_bits({2'b00, mk(1'b0, 5'b11111, 4'b0000, 4'b0000)}, 14, 0);
        check_outs("R6", e1p, e2p, e2a, e2s);

        // R10: strobe after 14 + 4 bits latches the last 14 bits
        w = mk(1'b0, 5'b10110, 4'b1001, 4'b0110);
        send_bits({2'b00, w}, 14, 0);
        send_bits(16'h000B, 4, 0);
        strobe();
        model_latch({4'b1011, w[13:4]});
        check_outs("R10", e1p, e2p, e2a, e2s);
        // R10: strobe after 16 bits keeps bits 2..15
        send_bits(16'hA5C3, 16, 0);
        strobe();
        model_latch(14'(16'hA5C3 >> 2));
        check_outs("R10", e1p, e2p, e2a, e2s);

        // R8 R9: force the reference state, write while forced, release
        force_ref = 1;
        wait_clk(2);
        check_outs("R8", 5'd0, 5'd0, 4'd0, 4'd0);
        write_word(mk(1'b1, 5'b00111, 4'b1100, 4'b0011), 0);
        check_outs("R8", 5'd0, 5'd0, 4'd0, 4'd0);
        write_word(mk(1'b0, 5'b11001, 4'b0000, 4'b0000), 0);
        check_outs("R8", 5'd0, 5'd0, 4'd0, 4'd0);
        force_ref = 0;
        wait_clk(2);
        check_outs("R9", e1p, e2p, e2a, e2s);

        // R7: echo across a mixed pattern
        write_word(mk(1'b1, 5'b10101, 4'b0110, 4'b1001), 1);
        check_outs("R5", e1p, e2p, e2a, e2s);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule